// File: doc/BRIEF.md
# Serial Control and Status Register Slave

This block is a serial-peripheral slave that takes 16-bit control frames from a master and, in the same frame, returns a 16-bit status word. The three serial pins (clock, active-low select, data in) are synchronized into the system clock domain, and all edge detection happens there. The system clock must run at least four times faster than the serial clock.

Each frame carries a 2-bit register address, an 8-bit data field that goes to the register the address picks, and a 6-bit field that is updated on every committed frame whatever the address is. A frame takes effect only when select is released. Until then, the settings already committed stay in force.

The serial output shifts out the status word that was captured when select fell. It then passes on the received bits 16 clocks late, so several devices can be chained. Outside a frame the output-enable is low, so a pad driver can put the line in high impedance.

Top module: `spi_ctl_slave`

## Requirements
- R1: While reset is asserted, every control register, the common field and the output-enable are zero, and the serial output is low.
- R2: Bits are sampled on falling serial-clock edges, most significant bit first. In the committed 16-bit word, bits 15:14 are the address, bits 13:6 are the data for the register at that address, and bits 5:0 are the common field.
- R3: The control registers and the common field change only when select is released at the end of a valid frame. They hold their values at every other time, including during a frame.
- R4: A frame whose falling-clock count is zero or not a multiple of 16 is discarded and no register changes.
- R5: When select falls, the status input is captured. Its bits appear on the serial output most significant bit first, and a new bit is presented after each rising edge that follows a falling edge. Later changes on the status input have no effect on that frame.
- R6: The output-enable is high only from select falling to select rising. While it is low, the serial output is low.
- R7: After the 16 status bits, the serial output repeats the received bits in order, delayed by 16 clocks. On a frame of 32 (or 16·n) clocks, the last 16 bits received are committed.
- R8: A commit changes at most one addressed register. All others keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Enable for the serial output pad driver |
| status_i | input | 16 | Status word captured at the start of a frame |
| ctl_bank_o | output | 32 | Four 8-bit control registers; register k is at bits 8k+7:8k |
| common_o | output | 6 | Address-independent control field |

## Verification
Every pin event passes through two synchronizer stages and one edge-detect register. Each result (a shifted output bit, an output-enable change, a register commit) is therefore due on the third system clock edge after the pin changes.

The bench drives pins on falling system-clock edges and waits four falling edges before it samples anything that responds to a pin event. The register outputs are compared with a behavioural model a quarter period after every rising edge. The only exception is the four-cycle window after select is released, during which the commit is allowed to land; the model is updated at the end of that window.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int DEF_FRAME_W  = 16;
  localparam int DEF_ADDR_W   = 2;
  localparam int DEF_DATA_W   = 8;
  localparam int DEF_COMMON_W = 6;
  localparam int DEF_SYNC     = 2;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_start,
  output logic cs_end,
  output logic mosi_s
);
  // bit 2: select, bit 1: clock, bit 0: data
  localparam logic [2:0] IDLE = 3'b100;

  logic [STAGES-1:0][2:0] stage_q;
  logic [1:0]             prev_q;
  logic                   csn_s, sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{IDLE}};
      prev_q  <= 2'b10;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], {csn_i, sclk_i, mosi_i}};
      prev_q  <= {csn_s, sclk_s};
    end
  end

  assign csn_s     = stage_q[STAGES-1][2];
  assign sclk_s    = stage_q[STAGES-1][1];
  assign mosi_s    = stage_q[STAGES-1][0];
  assign sclk_rise = sclk_s & ~prev_q[0];
  assign sclk_fall = ~sclk_s & prev_q[0];
  assign cs_start  = ~csn_s & prev_q[1];
  assign cs_end    = csn_s & ~prev_q[1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               cs_start,
  input  logic               cs_end,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] status_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               commit_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] in_q, in_d, out_q, out_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               wrap_q, wrap_d, act_q, act_d, en;

  always_comb begin
    in_d   = in_q;
    out_d  = out_q;
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    act_d  = act_q;
    if (cs_start) begin
      act_d  = 1'b1;
      out_d  = status_i;
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else if (act_q) begin
      if (sclk_fall) begin
        in_d = {in_q[FRAME_W-2:0], mosi_s};
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          wrap_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      // the first rising edge of a frame only presents the status MSB
      if (sclk_rise && (cnt_q != '0 || wrap_q))
        out_d = {out_q[FRAME_W-2:0], in_q[0]};
      if (cs_end)
        act_d = 1'b0;
    end
  end

  assign en = cs_start | (act_q & (sclk_fall | sclk_rise | cs_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      out_q  <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (en) begin
      in_q   <= in_d;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
      act_q  <= act_d;
    end
  end

  assign miso_o    = act_q & out_q[FRAME_W-1];
  assign miso_oe_o = act_q;
  assign frame_o   = in_q;
  assign commit_o  = cs_end & act_q & wrap_q & (cnt_q == '0);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int COMMON_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           data,
  input  logic [COMMON_W-1:0]         common,
  output logic [(2**ADDR_W)*DATA_W-1:0] bank_o,
  output logic [COMMON_W-1:0]         common_o
);
  localparam int NREG = 2 ** ADDR_W;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    logic              we;
    assign we = commit && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (we) val_q <= data;
    end
    assign bank_o[g*DATA_W +: DATA_W] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      common_o <= '0;
    else if (commit) common_o <= common;
  end
endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave
  import spi_ctl_pkg::*;
#(
  parameter int FRAME_W     = DEF_FRAME_W,
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int COMMON_W    = DEF_COMMON_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          spi_sclk,
  input  logic                          spi_csn,
  input  logic                          spi_mosi,
  output logic                          spi_miso,
  output logic                          spi_miso_oe,
  input  logic [FRAME_W-1:0]            status_i,
  output logic [(2**ADDR_W)*DATA_W-1:0] ctl_bank_o,
  output logic [COMMON_W-1:0]           common_o
);
  localparam int NREG = 2 ** ADDR_W;
  localparam int DATA_LSB = FRAME_W - ADDR_W - DATA_W;

  logic sclk_rise_w, sclk_fall_w, cs_start_w, cs_end_w, mosi_w, commit_w;
  logic [FRAME_W-1:0] frame_w;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(spi_sclk), .csn_i(spi_csn), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise_w), .sclk_fall(sclk_fall_w),
    .cs_start(cs_start_w), .cs_end(cs_end_w), .mosi_s(mosi_w)
  );

  spi_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise_w), .sclk_fall(sclk_fall_w),
    .cs_start(cs_start_w), .cs_end(cs_end_w), .mosi_s(mosi_w),
    .status_i(status_i),
    .miso_o(spi_miso), .miso_oe_o(spi_miso_oe),
    .frame_o(frame_w), .commit_o(commit_w)
  );

  spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMMON_W(COMMON_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit_w),
    .addr(frame_w[FRAME_W-1 -: ADDR_W]),
    .data(frame_w[DATA_LSB +: DATA_W]),
    .common(frame_w[COMMON_W-1:0]),
    .bank_o(ctl_bank_o), .common_o(common_o)
  );
endmodule

// File: rtl/spi_ctl_slave_chk.sv
module spi_ctl_slave_chk #(
  parameter int NREG     = 4,
  parameter int DATA_W   = 8,
  parameter int COMMON_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     miso,
  input logic                     miso_oe,
  input logic [NREG*DATA_W-1:0]   bank,
  input logic [COMMON_W-1:0]      common,
  input logic                     commit,
  input logic                     frame_end
);
  logic [NREG*DATA_W-1:0] bank_q;
  logic [NREG-1:0]        changed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank;
  end

  always_comb
    for (int k = 0; k < NREG; k++)
      changed[k] = bank_q[k*DATA_W +: DATA_W] != bank[k*DATA_W +: DATA_W];

  always @(posedge clk)
    if (!rst_n)
      p_reset_clear_r1: assert (bank == '0 && common == '0 && !miso_oe && !miso);

  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank));

  p_common_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(common));

  p_quiet_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

  p_oe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe && !frame_end |=> miso_oe);

  p_one_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(changed));
endmodule

bind spi_ctl_slave spi_ctl_slave_chk #(
  .NREG(NREG), .DATA_W(DATA_W), .COMMON_W(COMMON_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miso(spi_miso), .miso_oe(spi_miso_oe),
  .bank(ctl_bank_o), .common(common_o), .commit(commit_w), .frame_end(cs_end_w)
);

// File: tb/spi_ctl_slave_test.sv
module spi_ctl_slave_test;
  localparam int PERIOD = 10;
  localparam int WD_CYCLES = 50000;

  logic        clk, rst_n, sclk, csn, mosi;
  logic        miso, miso_oe;
  logic [15:0] status;
  logic [31:0] bank;
  logic [5:0]  common;

  int errors = 0, checks = 0;
  bit running = 0, in_commit = 0, done = 0;
  logic [7:0] mreg [4];
  logic [5:0] mcommon;

  spi_ctl_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .status_i(status),
    .ctl_bank_o(bank), .common_o(common)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_bank();
    return {mreg[3], mreg[2], mreg[1], mreg[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // model compare every clock, except in the window where a commit may land
  always @(posedge clk) begin
    #(PERIOD/4);
    if (running && !in_commit)
      check(bank === exp_bank() && common === mcommon, "R2/R3", "register outputs",
            {26'd0, common, bank}, {26'd0, mcommon, exp_bank()});
  end

  task automatic run_frame(input int nbits, input logic [31:0] word, input logic [15:0] stat);
    logic exp;
    logic [15:0] lw;
    status = stat;
    @(negedge clk) csn = 1'b0;
    repeat (4) @(negedge clk);
    status = ~stat;  // R5: must not reach this frame
    for (int i = 0; i < nbits; i++) begin
      mosi = word[nbits-1-i];
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      exp = (i < 16) ? stat[15-i] : word[nbits-1-(i-16)];
      check(miso_oe === 1'b1, "R6", "enable inside frame", {63'd0, miso_oe}, 64'd1);
      check(miso === exp, (i < 16) ? "R5" : "R7", "serial output bit", {63'd0, miso}, {63'd0, exp});
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    in_commit = 1'b1;
    csn = 1'b1;
    repeat (4) @(negedge clk);
    if (nbits > 0 && nbits % 16 == 0) begin
      lw = word[15:0];
      mreg[lw[15:14]] = lw[13:6];
      mcommon = lw[5:0];
    end
    in_commit = 1'b0;
    check(miso_oe === 1'b0 && miso === 1'b0, "R6", "idle line after frame",
          {62'd0, miso_oe, miso}, 64'd0);
  endtask

  function automatic logic [15:0] mk(input logic [1:0] a, input logic [7:0] d, input logic [5:0] c);
    return {a, d, c};
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) mreg[k] = '0;
    mcommon = '0;
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0; status = 16'h0;
    repeat (3) @(negedge clk);
    check(bank === '0 && common === '0 && miso_oe === 1'b0 && miso === 1'b0, "R1",
          "reset state", {25'd0, miso_oe, common, bank}, 64'd0);
    rst_n = 1'b1;
    running = 1'b1;
    repeat (3) @(negedge clk);

    run_frame(16, {16'd0, mk(2'd0, 8'hA5, 6'h15)}, 16'hC3A1);
    run_frame(16, {16'd0, mk(2'd1, 8'h3C, 6'h2A)}, 16'h5A0F);
    check(bank[7:0] === 8'hA5, "R8", "reg0 kept after write to reg1", {56'd0, bank[7:0]}, 64'hA5);
    run_frame(16, {16'd0, mk(2'd3, 8'hFF, 6'h01)}, 16'hFFFF);
    run_frame(10, {22'd0, 10'h2B7}, 16'h0001);
    check(bank === exp_bank() && common === mcommon, "R4", "10-bit frame discarded",
          {26'd0, common, bank}, {26'd0, mcommon, exp_bank()});
    run_frame(32, {mk(2'd2, 8'h77, 6'h0F), mk(2'd2, 8'h81, 6'h3E)}, 16'h8000);
    check(bank[23:16] === 8'h81 && common === 6'h3E, "R7", "chained frame commits last word",
          {50'd0, common, bank[23:16]}, {50'd0, 6'h3E, 8'h81});
    run_frame(20, {12'd0, 20'hFACE5}, 16'h1234);
    check(bank === exp_bank() && common === mcommon, "R4", "20-bit frame discarded",
          {26'd0, common, bank}, {26'd0, mcommon, exp_bank()});
    run_frame(16, {16'd0, mk(2'd0, 8'h00, 6'h00)}, 16'h0000);
    check(bank === 32'hFF81_3C00 && common === 6'h00, "R2", "clear reg0 and common",
          {26'd0, common, bank}, {26'd0, 6'h00, 32'hFF81_3C00});

    running = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule